// File: doc/BRIEF.md
# Complementary Dead-Time Generator with Staged Delay Update

This block turns a single PWM waveform into a complementary pair of drive signals with a programmable guard interval between them. The high-side output copies the input, but its rising edge is held back by a programmable number of clock cycles. The low-side output is the inverse of the input, and its rising edge is held back by a second count after the input falls. Both outputs drop at once when the input edge that ends their phase arrives. So the pair never overlaps.

Each delay count is written through a write port and kept in a staging register that can be read back. A two-bit policy input decides when a staged count reaches the live delay logic. The count can be taken on the next clock edge. It can be taken on the next counter-zero strobe from the PWM timebase. Or it can be taken on the first counter-zero strobe after a chip-wide update request. A count that is replaced before it is taken is lost. With the enable low, the delays play no part and the outputs are a plain complementary copy of the input.

Top module: `dtgen_top`

## Requirements
- R1: After reset both staging registers read zero. Both live delays are zero, so with the enable high the outputs are a pure complement of the input.
- R2: A write keeps the low DLY_W bits of the write data. The readback shows that value in its low DLY_W bits, and every bit above DLY_W reads zero.
- R3: With the enable high, out_hi goes high exactly D_r cycles after pwm_in rises, where D_r is the live rising delay. It goes low in the same cycle that pwm_in falls.
- R4: With the enable high, out_lo goes high exactly D_f cycles after pwm_in falls, where D_f is the live falling delay. It goes low in the same cycle that pwm_in rises.
- R5: A delay equal to or longer than the matching input phase keeps that output low for the whole phase.
- R6: A delay of zero gives an output with no dead time on that edge.
- R7: With db_en low, out_hi equals pwm_in and out_lo equals its inverse, whatever the delay values are.
- R8: Policy 0 (immediate): a write becomes the live delay on the clock edge that captures it.
- R9: Policy 1 (local): a staged write becomes live on the clock edge where cnt_zero is high, and not before.
- R10: Policy 2 or 3 (global): a cnt_zero strobe is ignored until a glb_req pulse has been captured on an earlier edge. The staged value then becomes live on the next cnt_zero strobe.
- R11: If a second write arrives before a staged value becomes live, only the newer value is ever used.
- R12: Applying a global update consumes the request. A later write needs a fresh glb_req before a strobe can make it live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | PWM waveform to split |
| cnt_zero | input | 1 | One-cycle strobe when the PWM counter reaches zero |
| glb_req | input | 1 | One-cycle chip-wide update request |
| db_en | input | 1 | Dead-time insertion enable |
| upd_mode | input | 2 | Update policy: 0 immediate, 1 local, 2 or 3 global |
| wr_rise | input | 1 | Write strobe for the rising-delay register |
| wr_fall | input | 1 | Write strobe for the falling-delay register |
| wr_data | input | REG_W | Write data |
| rd_rise | output | REG_W | Staged rising delay, zero-extended |
| rd_fall | output | REG_W | Staged falling delay, zero-extended |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side (complementary) output |

## Verification
The bench builds the block with DLY_W set to 5 and REG_W left at 32. With these values the largest count, 31, is longer than any pulse the bench drives, which brings the R5 case within reach. Write data wider than five bits shows the truncation and the zeroed upper readback. Small counts keep each delay measurement to a dozen cycles, so every update policy and the lost-value case can be told apart by the output timing alone.

// File: rtl/dtgen_pkg.sv
package dtgen_pkg;

  typedef enum logic [1:0] {
    UPD_NOW    = 2'd0,
    UPD_LOCAL  = 2'd1,
    UPD_GLOBAL = 2'd2,
    UPD_GLOB_B = 2'd3
  } upd_mode_e;

  function automatic logic is_global(upd_mode_e m);
    return (m == UPD_GLOBAL) || (m == UPD_GLOB_B);
  endfunction

  // Output may open once the phase has lasted at least 'dly' cycles.
  function automatic logic phase_open(logic [31:0] elapsed, logic [31:0] dly);
    return elapsed >= dly;
  endfunction

endpackage

// File: rtl/dtgen_delay_reg.sv
module dtgen_delay_reg
  import dtgen_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  upd_mode_e        mode,
  input  logic             wr,
  input  logic [DLY_W-1:0] wr_val,
  input  logic             cnt_zero,
  input  logic             armed,
  output logic [DLY_W-1:0] staged,
  output logic [DLY_W-1:0] live,
  output logic             apply
);

  logic pending;

  assign apply = pending && cnt_zero &&
                 ((mode == UPD_LOCAL) || (is_global(mode) && armed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged  <= '0;
      live    <= '0;
      pending <= 1'b0;
    end else if (wr) begin
      staged <= wr_val;
      if (mode == UPD_NOW) begin
        live    <= wr_val;
        pending <= 1'b0;
      end else begin
        pending <= 1'b1;
      end
    end else if (apply) begin
      live    <= staged;
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/dtgen_edge.sv
module dtgen_edge
  import dtgen_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig,
  input  logic [DLY_W-1:0] dly,
  output logic             out
);

  logic [DLY_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (!rst_n)             elapsed <= '0;
    else if (!sig)          elapsed <= '0;
    else if (elapsed < dly) elapsed <= elapsed + 1'b1;
  end

  assign out = sig && phase_open(32'(elapsed), 32'(dly));

endmodule

// File: rtl/dtgen_top.sv
module dtgen_top
  import dtgen_pkg::*;
#(
  parameter int DLY_W = 12,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             cnt_zero,
  input  logic             glb_req,
  input  logic             db_en,
  input  logic [1:0]       upd_mode,
  input  logic             wr_rise,
  input  logic             wr_fall,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_rise,
  output logic [REG_W-1:0] rd_fall,
  output logic             out_hi,
  output logic             out_lo
);

  localparam int NCH = 2;

  upd_mode_e        mode;
  logic             glb_arm;
  logic [NCH-1:0]   wr_sel;
  logic [NCH-1:0]   ch_sig;
  logic [NCH-1:0]   ch_out;
  logic [NCH-1:0]   ch_apply;
  logic [DLY_W-1:0] staged_q [NCH];
  logic [DLY_W-1:0] live_q   [NCH];
  logic [DLY_W-1:0] rise_live;
  logic [DLY_W-1:0] fall_live;

  assign mode   = upd_mode_e'(upd_mode);
  assign wr_sel = {wr_fall, wr_rise};
  assign ch_sig = {~pwm_in, pwm_in};

  // Global request is held until a counter-zero strobe consumes it.
  always_ff @(posedge clk) begin
    if (!rst_n)                    glb_arm <= 1'b0;
    else if (cnt_zero && glb_arm)  glb_arm <= 1'b0;
    else if (glb_req)              glb_arm <= 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dtgen_delay_reg #(.DLY_W(DLY_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .wr       (wr_sel[c]),
      .wr_val   (wr_data[DLY_W-1:0]),
      .cnt_zero (cnt_zero),
      .armed    (glb_arm),
      .staged   (staged_q[c]),
      .live     (live_q[c]),
      .apply    (ch_apply[c])
    );

    dtgen_edge #(.DLY_W(DLY_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   (ch_sig[c]),
      .dly   (live_q[c]),
      .out   (ch_out[c])
    );
  end

  assign rise_live = live_q[0];
  assign fall_live = live_q[1];

  assign rd_rise = {{(REG_W-DLY_W){1'b0}}, staged_q[0]};
  assign rd_fall = {{(REG_W-DLY_W){1'b0}}, staged_q[1]};

  assign out_hi = db_en ? ch_out[0] :  pwm_in;
  assign out_lo = db_en ? ch_out[1] : ~pwm_in;

endmodule

// File: rtl/dtgen_checker.sv
module dtgen_checker #(
  parameter int DLY_W = 12,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_in,
  input logic             db_en,
  input logic             cnt_zero,
  input logic [1:0]       upd_mode,
  input logic             glb_arm,
  input logic [DLY_W-1:0] rise_live,
  input logic [DLY_W-1:0] fall_live,
  input logic [REG_W-1:0] rd_rise,
  input logic [REG_W-1:0] rd_fall,
  input logic             out_hi,
  input logic             out_lo
);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise[REG_W-1:DLY_W] == '0) && (rd_fall[REG_W-1:DLY_W] == '0));

  assert_hi_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && !pwm_in) |-> !out_hi);

  assert_lo_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && pwm_in) |-> !out_lo);

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !db_en |-> (out_hi == pwm_in) && (out_lo == !pwm_in));

  assert_local_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode == 2'd1 && !cnt_zero) |=> ($stable(fall_live) && $stable(rise_live)));

  assert_global_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode[1] && !glb_arm) |=> ($stable(fall_live) && $stable(rise_live)));

  assert_arm_consumed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && glb_arm) |=> !glb_arm);

endmodule

bind dtgen_top dtgen_checker #(.DLY_W(DLY_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_in    (pwm_in),
  .db_en     (db_en),
  .cnt_zero  (cnt_zero),
  .upd_mode  (upd_mode),
  .glb_arm   (glb_arm),
  .rise_live (rise_live),
  .fall_live (fall_live),
  .rd_rise   (rd_rise),
  .rd_fall   (rd_fall),
  .out_hi    (out_hi),
  .out_lo    (out_lo)
);

// File: tb/dtgen_top_bench.sv
`timescale 1ns/1ps
module dtgen_top_bench;

  localparam int DLY_W = 5;
  localparam int REG_W = 32;
  localparam int MW    = 12;   // measurement window per phase

  // Vector fields: [31:24] rise delay, [23:16] fall delay, [15:8] high width, [7:0] low width
  localparam logic [31:0] VEC [6] = '{
    {8'd2,  8'd3,  8'd6,  8'd6},
    {8'd0,  8'd0,  8'd4,  8'd4},
    {8'd5,  8'd1,  8'd3,  8'd8},
    {8'd1,  8'd7,  8'd5,  8'd7},
    {8'd31, 8'd31, 8'd10, 8'd10},
    {8'd4,  8'd2,  8'd9,  8'd3}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwm_in = 1'b0;
  logic             cnt_zero = 1'b0;
  logic             glb_req = 1'b0;
  logic             db_en = 1'b1;
  logic [1:0]       upd_mode = 2'd0;
  logic             wr_rise = 1'b0;
  logic             wr_fall = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_rise, rd_fall;
  logic             out_hi, out_lo;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  dtgen_top #(.DLY_W(DLY_W), .REG_W(REG_W)) u_dtgen_top (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cnt_zero(cnt_zero),
    .glb_req(glb_req), .db_en(db_en), .upd_mode(upd_mode),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .wr_data(wr_data),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .out_hi(out_hi), .out_lo(out_lo)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_reg(bit fall, logic [REG_W-1:0] v);
    tick();
    wr_data = v;
    if (fall) wr_fall = 1'b1; else wr_rise = 1'b1;
    tick();
    wr_fall = 1'b0;
    wr_rise = 1'b0;
  endtask

  task automatic pulse_zero();
    tick(); cnt_zero = 1'b1;
    tick(); cnt_zero = 1'b0;
  endtask

  task automatic pulse_req();
    tick(); glb_req = 1'b1;
    tick(); glb_req = 1'b0;
  endtask

  // Drive one high and one low phase; count output high samples in each.
  task automatic run_phases(int hw, int lw, output int hi_n, output int lo_n,
                            output int leak);
    hi_n = 0; lo_n = 0; leak = 0;
    for (int k = 0; k < hw; k++) begin
      tick(); pwm_in = 1'b1; #1;
      if (out_hi) hi_n++;
      if (out_lo) leak++;
    end
    for (int k = 0; k < lw; k++) begin
      tick(); pwm_in = 1'b0; #1;
      if (out_lo) lo_n++;
      if (out_hi) leak++;
    end
  endtask

  // Returns the delay each output showed in a MW-cycle phase.
  task automatic measure(output int dr, output int df);
    int h, l, lk;
    run_phases(MW, MW, h, l, lk);
    dr = MW - h;
    df = MW - l;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int dr, df, h, l, lk;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); #1;
    // R1: reset state
    chk("R1 rd_rise", int'(rd_rise), 0);
    chk("R1 rd_fall", int'(rd_fall), 0);
    chk("R1 out_lo with low input", int'(out_lo), 1);
    run_phases(3, 3, h, l, lk);
    chk("R1 zero-delay high count", h, 3);
    chk("R1 zero-delay low count", l, 3);

    // R2: truncation and zero upper readback
    write_reg(1'b1, 32'hFFFF_FFE5);
    #1;
    chk("R2 rd_fall masked", int'(rd_fall), int'(32'hFFFF_FFE5 & 32'h1F));
    chk("R2 rd_rise untouched", int'(rd_rise), 0);

    // Vector table, immediate policy (R3 R4 R5 R6 R8)
    foreach (VEC[i]) begin
      int r, f, hw, lw, eh, el;
      r  = int'(VEC[i][31:24]);
      f  = int'(VEC[i][23:16]);
      hw = int'(VEC[i][15:8]);
      lw = int'(VEC[i][7:0]);
      write_reg(1'b0, 32'(r));
      write_reg(1'b1, 32'(f));
      eh = (hw > r) ? hw - r : 0;
      el = (lw > f) ? lw - f : 0;
      run_phases(hw, lw, h, l, lk);
      chk($sformatf("R3/R5/R6 vec%0d out_hi high cycles", i), h, eh);
      chk($sformatf("R4/R5/R6 vec%0d out_lo high cycles", i), l, el);
      chk($sformatf("R3/R4 vec%0d output in wrong phase", i), lk, 0);
    end

    // R7: bypass when disabled (delays now 4 and 2)
    tick(); db_en = 1'b0; pwm_in = 1'b1; #1;
    chk("R7 out_hi follows input", int'(out_hi), 1);
    chk("R7 out_lo inverse", int'(out_lo), 0);
    tick(); pwm_in = 1'b0; #1;
    chk("R7 out_hi low", int'(out_hi), 0);
    chk("R7 out_lo high", int'(out_lo), 1);
    tick(); db_en = 1'b1;

    // R9: local policy
    upd_mode = 2'd1;
    write_reg(1'b1, 32'd6);
    write_reg(1'b0, 32'd2);
    measure(dr, df);
    chk("R9 fall held before strobe", df, 2);
    chk("R9 rise held before strobe", dr, 4);
    pulse_zero();
    measure(dr, df);
    chk("R9 fall applied at strobe", df, 6);
    chk("R9 rise applied at strobe", dr, 2);

    // R11: overwrite before apply
    write_reg(1'b1, 32'd4);
    write_reg(1'b1, 32'd8);
    #1;
    chk("R11 readback newest", int'(rd_fall), 8);
    pulse_zero();
    measure(dr, df);
    chk("R11 newest value live", df, 8);

    // R10: global policy
    upd_mode = 2'd2;
    write_reg(1'b1, 32'd3);
    pulse_zero();
    measure(dr, df);
    chk("R10 strobe without request ignored", df, 8);
    pulse_req();
    pulse_zero();
    measure(dr, df);
    chk("R10 applied after request and strobe", df, 3);

    // R12: request consumed
    upd_mode = 2'd3;
    write_reg(1'b1, 32'd5);
    pulse_zero();
    measure(dr, df);
    chk("R12 stale request not reused", df, 3);
    pulse_req();
    pulse_zero();
    measure(dr, df);
    chk("R12 fresh request applies", df, 5);

    // R8: immediate policy takes effect with no strobe
    upd_mode = 2'd0;
    write_reg(1'b0, 32'd7);
    measure(dr, df);
    chk("R8 immediate rise", dr, 7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule